// File: doc/BRIEF.md
# Bus Master Read/Write Arbiter

This block sits inside a bus master and decides whether the read-command controller or the write-command controller drives the one shared bus request. Each controller hands over a request by pulsing its request line for one clock with an address and a transfer length. The arbiter latches these into a holding slot for that controller and marks the slot pending. When the bus side is free, it picks one pending slot. It then drives the bus request with the latched address and length and a read/not-write qualifier, and raises a grant toward the chosen controller.

Ownership lasts until the bus answers the current request. A completion ends the transfer and frees the slot. A rearbitrate answer means the bus wants the transfer tried again, and the policy here is deliberately asymmetric. A retried read steps aside for any pending write. A retried write keeps the bus and pending reads wait. This ordering lets writes overtake reads, which a downstream bridge needs to avoid an ordering deadlock. When neither side is forced by a retry and both are waiting, the grant alternates between them. All logic runs on one clock with a synchronous, active-high reset.

Top module: `rw_bus_arbiter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both grants, drops busReq and discards any request captured before it, so that nothing is granted after reset is released until a new request arrives.
- R2: A one-cycle pulse on rdReq or wrReq, seen at an edge while that controller has nothing pending, captures its address and length. With the bus idle, the matching grant is high after the following edge. busAddr and busLen then carry the captured values, and busRnW is 1 for a read and 0 for a write.
- R3: At most one of rdGrant and wrGrant is high. busReq is high exactly when a grant is high, and busAddr and busLen read zero while busReq is low.
- R4: A grant stays high, with busAddr and busLen unchanged, for every cycle in which neither busDone nor busRearb is high.
- R5: busDone during a grant ends it: after the next edge no grant is high and that controller's request is no longer pending. busDone takes precedence over busRearb in the same cycle.
- R6: busRearb during a read grant while a write is pending moves the grant to the write after the next edge. The read stays pending and is granted with its original address and length once the bus is free again.
- R7: busRearb during a read grant with no write pending keeps the read granted after the next edge, with the same address and length.
- R8: busRearb during a write grant keeps the write granted after the next edge, even when a read is pending.
- R9: When the bus is idle and both controllers are pending, the grant goes to the side not chosen by the previous idle-time decision. After reset, read goes first.
- R10: A request pulse from a controller that already has a pending or granted request is ignored: the address and length of the earlier request stay in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rdReq | input | 1 | Read controller request pulse |
| rdAddr | input | ADDR_W | Read start address, sampled with rdReq |
| rdLen | input | LEN_W | Read length, sampled with rdReq |
| rdGrant | output | 1 | Bus currently owned by the read request |
| wrReq | input | 1 | Write controller request pulse |
| wrAddr | input | ADDR_W | Write start address, sampled with wrReq |
| wrLen | input | LEN_W | Write length, sampled with wrReq |
| wrGrant | output | 1 | Bus currently owned by the write request |
| busReq | output | 1 | Request to the shared bus |
| busRnW | output | 1 | 1 = read, 0 = write |
| busAddr | output | ADDR_W | Address of the owning request |
| busLen | output | LEN_W | Length of the owning request |
| busDone | input | 1 | Bus completed the current request |
| busRearb | input | 1 | Bus asks for the current request to be retried |

## Verification
The bench builds the arbiter with a 12-bit address and a 4-bit length. These sizes are small enough to pick distinct recognisable values per request, and they still let an all-ones length (15) reach the top bit of the length slot. With narrow slots, a wrong selection between the read and write holding registers shows up at once on busAddr and busLen. This applies when a retried read hands the bus to a write and later comes back with its original values. The same holds when an ignored second request would otherwise overwrite a waiting slot.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int CH_RD  = 0;
  localparam int CH_WR  = 1;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RD   = 2'd1,
    OWN_WR   = 2'd2
  } owner_e;

  // Strobes from control to the holding datapath
  typedef struct packed {
    logic [NUM_CH-1:0] capture;  // load a slot and mark it pending
    logic [NUM_CH-1:0] clear;    // retire a slot
    logic              selWr;    // bus fields come from the write slot
    logic              drive;    // bus fields are valid
  } dpStrobe_t;

endpackage

// File: rtl/arb_hold.sv
module arb_hold
  import arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dpStrobe_t                      strb,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  addrIn,
  input  logic [NUM_CH-1:0][LEN_W-1:0]   lenIn,
  output logic [NUM_CH-1:0]              pend,
  output logic [ADDR_W-1:0]              busAddr,
  output logic [LEN_W-1:0]               busLen
);

  logic [NUM_CH-1:0][ADDR_W-1:0] slotAddr;
  logic [NUM_CH-1:0][LEN_W-1:0]  slotLen;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[ch]     <= 1'b0;
        slotAddr[ch] <= '0;
        slotLen[ch]  <= '0;
      end else if (strb.capture[ch]) begin
        pend[ch]     <= 1'b1;
        slotAddr[ch] <= addrIn[ch];
        slotLen[ch]  <= lenIn[ch];
      end else if (strb.clear[ch]) begin
        pend[ch]     <= 1'b0;
      end
    end
  end

  always_comb begin
    busAddr = '0;
    busLen  = '0;
    if (strb.drive) begin
      if (strb.selWr) begin
        busAddr = slotAddr[CH_WR];
        busLen  = slotLen[CH_WR];
      end else begin
        busAddr = slotAddr[CH_RD];
        busLen  = slotLen[CH_RD];
      end
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [NUM_CH-1:0] pend,
  input  logic              busDone,
  input  logic              busRearb,
  output dpStrobe_t         strb,
  output logic              rdGrant,
  output logic              wrGrant,
  output logic              busReq,
  output logic              busRnW
);

  owner_e ownerQ, ownerNext;
  logic   preferWr;   // idle-time tie goes to write when set

  always_comb begin
    ownerNext = ownerQ;
    unique case (ownerQ)
      OWN_NONE: begin
        if (pend[CH_RD] && pend[CH_WR])
          ownerNext = preferWr ? OWN_WR : OWN_RD;
        else if (pend[CH_RD])
          ownerNext = OWN_RD;
        else if (pend[CH_WR])
          ownerNext = OWN_WR;
        else
          ownerNext = OWN_NONE;
      end
      OWN_RD: begin
        if (busDone)
          ownerNext = OWN_NONE;
        else if (busRearb && pend[CH_WR])
          ownerNext = OWN_WR;   // retried read yields
        else
          ownerNext = OWN_RD;
      end
      OWN_WR: begin
        if (busDone)
          ownerNext = OWN_NONE;
        else
          ownerNext = OWN_WR;   // retried write keeps bus
      end
      default: ownerNext = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ownerQ   <= OWN_NONE;
      preferWr <= 1'b0;
    end else begin
      ownerQ <= ownerNext;
      if (ownerQ == OWN_NONE && ownerNext != OWN_NONE)
        preferWr <= (ownerNext == OWN_RD);
    end
  end

  always_comb begin
    strb               = '0;
    strb.capture[CH_RD] = rdReq && !pend[CH_RD];
    strb.capture[CH_WR] = wrReq && !pend[CH_WR];
    strb.clear[CH_RD]   = (ownerQ == OWN_RD) && busDone;
    strb.clear[CH_WR]   = (ownerQ == OWN_WR) && busDone;
    strb.selWr          = (ownerQ == OWN_WR);
    strb.drive          = (ownerQ != OWN_NONE);
  end

  assign rdGrant = (ownerQ == OWN_RD);
  assign wrGrant = (ownerQ == OWN_WR);
  assign busReq  = (ownerQ != OWN_NONE);
  assign busRnW  = (ownerQ == OWN_RD);

endmodule

// File: rtl/rw_bus_arbiter.sv
module rw_bus_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [LEN_W-1:0]  rdLen,
  output logic              rdGrant,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LEN_W-1:0]  wrLen,
  output logic              wrGrant,
  output logic              busReq,
  output logic              busRnW,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LEN_W-1:0]  busLen,
  input  logic              busDone,
  input  logic              busRearb
);

  dpStrobe_t                     strb;
  logic [NUM_CH-1:0]             pend;
  logic [NUM_CH-1:0][ADDR_W-1:0] addrIn;
  logic [NUM_CH-1:0][LEN_W-1:0]  lenIn;
  logic                          rdPend, wrPend;

  assign addrIn[CH_RD] = rdAddr;
  assign addrIn[CH_WR] = wrAddr;
  assign lenIn[CH_RD]  = rdLen;
  assign lenIn[CH_WR]  = wrLen;
  assign rdPend        = pend[CH_RD];
  assign wrPend        = pend[CH_WR];

  arb_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rdReq    (rdReq),
    .wrReq    (wrReq),
    .pend     (pend),
    .busDone  (busDone),
    .busRearb (busRearb),
    .strb     (strb),
    .rdGrant  (rdGrant),
    .wrGrant  (wrGrant),
    .busReq   (busReq),
    .busRnW   (busRnW)
  );

  arb_hold #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .addrIn  (addrIn),
    .lenIn   (lenIn),
    .pend    (pend),
    .busAddr (busAddr),
    .busLen  (busLen)
  );

endmodule

// File: rtl/rw_bus_arbiter_chk.sv
module rw_bus_arbiter_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rdGrant,
  input logic              wrGrant,
  input logic              busReq,
  input logic              busRnW,
  input logic [ADDR_W-1:0] busAddr,
  input logic [LEN_W-1:0]  busLen,
  input logic              busDone,
  input logic              busRearb,
  input logic              rdPend,
  input logic              wrPend
);

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rdGrant, wrGrant}));

  assert_req_matches_grant_R3: assert property (@(posedge clk) disable iff (rst)
    busReq == (rdGrant || wrGrant));

  assert_idle_fields_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !busReq |-> (busAddr == '0 && busLen == '0));

  assert_qualifier_R2: assert property (@(posedge clk) disable iff (rst)
    busReq |-> (busRnW == rdGrant));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busDone && !busRearb) |=>
      (busReq && $stable(rdGrant) && $stable(busAddr) && $stable(busLen)));

  assert_done_release_R5: assert property (@(posedge clk) disable iff (rst)
    (busReq && busDone) |=> !busReq);

  assert_read_yields_R6: assert property (@(posedge clk) disable iff (rst)
    (rdGrant && busRearb && !busDone && wrPend) |=> (wrGrant && rdPend));

  assert_read_reissue_R7: assert property (@(posedge clk) disable iff (rst)
    (rdGrant && busRearb && !busDone && !wrPend) |=>
      (rdGrant && $stable(busAddr) && $stable(busLen)));

  assert_write_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (wrGrant && busRearb && !busDone) |=> (wrGrant && !rdGrant));

endmodule

bind rw_bus_arbiter rw_bus_arbiter_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rdGrant  (rdGrant),
  .wrGrant  (wrGrant),
  .busReq   (busReq),
  .busRnW   (busRnW),
  .busAddr  (busAddr),
  .busLen   (busLen),
  .busDone  (busDone),
  .busRearb (busRearb),
  .rdPend   (rdPend),
  .wrPend   (wrPend)
);

// File: tb/rw_bus_arbiter_test.sv
`timescale 1ns/1ps
module rw_bus_arbiter_test;

  localparam int AW = 12;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          rdReq, wrReq, busDone, busRearb;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [LW-1:0] rdLen, wrLen;
  logic          rdGrant, wrGrant, busReq, busRnW;
  logic [AW-1:0] busAddr;
  logic [LW-1:0] busLen;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;   // 50 MHz

  rw_bus_arbiter #(.ADDR_W(AW), .LEN_W(LW)) uut (
    .clk(clk), .rst(rst),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdLen(rdLen), .rdGrant(rdGrant),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrLen(wrLen), .wrGrant(wrGrant),
    .busReq(busReq), .busRnW(busRnW), .busAddr(busAddr), .busLen(busLen),
    .busDone(busDone), .busRearb(busRearb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    idleCycles(2);
    rst = 1'b0;
  endtask

  // Pulse one or both controllers for one cycle; returns at the next negedge
  task automatic pulse(input logic r, input logic [AW-1:0] ra, input logic [LW-1:0] rl,
                       input logic w, input logic [AW-1:0] wa, input logic [LW-1:0] wl);
    rdReq = r; rdAddr = ra; rdLen = rl;
    wrReq = w; wrAddr = wa; wrLen = wl;
    @(negedge clk);
    rdReq = 1'b0; wrReq = 1'b0;
  endtask

  task automatic respond(input logic d, input logic rb);
    busDone = d; busRearb = rb;
    @(negedge clk);
    busDone = 1'b0; busRearb = 1'b0;
  endtask

  task automatic expectOwner(input string tag, input logic r, input logic w,
                             input logic [AW-1:0] a, input logic [LW-1:0] l);
    chk({tag, " rdGrant"}, rdGrant, r);
    chk({tag, " wrGrant"}, wrGrant, w);
    chk({tag, " busReq"},  busReq, r | w);
    if (r | w) chk({tag, " busRnW"}, busRnW, r);
    chk({tag, " busAddr"}, busAddr, a);
    chk({tag, " busLen"},  busLen, l);
  endtask

  task automatic t_reset();
    expectOwner("R1 after reset", 0, 0, 0, 0);
    pulse(1, 12'h111, 4'h1, 0, 0, 0);
    doReset();
    idleCycles(2);
    expectOwner("R1 request dropped by reset", 0, 0, 0, 0);
  endtask

  task automatic t_singleRead();
    pulse(1, 12'hA5C, 4'hF, 0, 0, 0);
    expectOwner("R2 read not yet granted", 0, 0, 0, 0);
    @(negedge clk);
    expectOwner("R2 read granted", 1, 0, 12'hA5C, 4'hF);
    idleCycles(3);
    expectOwner("R4 read held", 1, 0, 12'hA5C, 4'hF);
    respond(1, 0);
    expectOwner("R5 read released", 0, 0, 0, 0);
    @(negedge clk);
    expectOwner("R5 read not regranted", 0, 0, 0, 0);
  endtask

  task automatic t_singleWrite();
    pulse(0, 0, 0, 1, 12'h3C0, 4'h7);
    @(negedge clk);
    expectOwner("R2 write granted", 0, 1, 12'h3C0, 4'h7);
    respond(1, 0);
    expectOwner("R5 write released", 0, 0, 0, 0);
  endtask

  task automatic t_roundRobin();
    doReset();
    pulse(1, 12'h101, 4'h2, 1, 12'h202, 4'h3);
    @(negedge clk);
    expectOwner("R9 read first after reset", 1, 0, 12'h101, 4'h2);
    respond(1, 0);
    @(negedge clk);
    expectOwner("R9 write after read", 0, 1, 12'h202, 4'h3);
    respond(1, 0);
    // A lone write grant leaves the tie pointing at read; set it to write
    pulse(1, 12'h303, 4'h4, 0, 0, 0);
    @(negedge clk);
    expectOwner("R9 lone read", 1, 0, 12'h303, 4'h4);
    respond(1, 0);
    pulse(1, 12'h404, 4'h5, 1, 12'h505, 4'h6);
    @(negedge clk);
    expectOwner("R9 write wins alternate tie", 0, 1, 12'h505, 4'h6);
    respond(1, 0);
    @(negedge clk);
    expectOwner("R9 read follows", 1, 0, 12'h404, 4'h5);
    respond(1, 0);
  endtask

  task automatic t_readYields();
    pulse(1, 12'h6A0, 4'h8, 0, 0, 0);
    @(negedge clk);
    pulse(0, 0, 0, 1, 12'h7B1, 4'h9);
    expectOwner("R6 read owns before retry", 1, 0, 12'h6A0, 4'h8);
    respond(0, 1);
    expectOwner("R6 write takes bus", 0, 1, 12'h7B1, 4'h9);
    respond(1, 0);
    expectOwner("R6 idle after write", 0, 0, 0, 0);
    @(negedge clk);
    expectOwner("R6 read back with original fields", 1, 0, 12'h6A0, 4'h8);
    respond(1, 0);
  endtask

  task automatic t_readReissue();
    pulse(1, 12'h8C2, 4'hA, 0, 0, 0);
    @(negedge clk);
    respond(0, 1);
    expectOwner("R7 read reissued", 1, 0, 12'h8C2, 4'hA);
    respond(0, 1);
    expectOwner("R7 read reissued twice", 1, 0, 12'h8C2, 4'hA);
    respond(1, 0);
  endtask

  task automatic t_writeKeeps();
    pulse(0, 0, 0, 1, 12'h9D3, 4'hB);
    @(negedge clk);
    pulse(1, 12'hAE4, 4'hC, 0, 0, 0);
    respond(0, 1);
    expectOwner("R8 write kept over read", 0, 1, 12'h9D3, 4'hB);
    respond(0, 1);
    expectOwner("R8 write kept again", 0, 1, 12'h9D3, 4'hB);
    respond(1, 0);
    @(negedge clk);
    expectOwner("R8 read served later", 1, 0, 12'hAE4, 4'hC);
    respond(1, 0);
  endtask

  task automatic t_ignoreRepeat();
    pulse(1, 12'hB11, 4'h1, 0, 0, 0);
    @(negedge clk);
    pulse(1, 12'hB22, 4'h2, 1, 12'hC33, 4'h3);
    pulse(0, 0, 0, 1, 12'hC44, 4'h4);
    expectOwner("R10 owner fields kept", 1, 0, 12'hB11, 4'h1);
    respond(1, 0);
    @(negedge clk);
    expectOwner("R10 waiting write kept first fields", 0, 1, 12'hC33, 4'h3);
    respond(1, 0);
    @(negedge clk);
    expectOwner("R10 nothing left", 0, 0, 0, 0);
  endtask

  task automatic t_doneBeatsRearb();
    pulse(1, 12'hD55, 4'h5, 0, 0, 0);
    @(negedge clk);
    pulse(0, 0, 0, 1, 12'hE66, 4'h6);
    respond(1, 1);
    expectOwner("R5 done wins over retry", 0, 0, 0, 0);
    @(negedge clk);
    expectOwner("R5 write next", 0, 1, 12'hE66, 4'h6);
    respond(1, 0);
    @(negedge clk);
    expectOwner("R5 read was retired", 0, 0, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; rdReq = 0; wrReq = 0; busDone = 0; busRearb = 0;
    rdAddr = 0; wrAddr = 0; rdLen = 0; wrLen = 0;
    idleCycles(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_singleRead();
    t_singleWrite();
    t_roundRobin();
    t_readYields();
    t_readReissue();
    t_writeKeeps();
    t_ignoreRepeat();
    t_doneBeatsRearb();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule